// File: doc/BRIEF.md
# Decode-Stage Hazard Stall and Fetch Squash Controller

This controller sits beside the decode stage of a five-stage in-order pipeline whose branches are compared and resolved in decode. Each cycle it looks at the two source register numbers of the instruction being decoded and at the destination, register-write and memory-read information of the instructions currently held in the execute-stage and memory-stage pipeline registers. From these it decides whether the decoding instruction must be held back. When it must, the fetch address and the fetch/decode register are frozen and a bubble (all control fields zero) is inserted into the execute-stage register.

Two families of hold are produced. Any instruction that reads a register being loaded by the instruction directly ahead of it is held for one cycle, after which the loaded value can be forwarded. A branch being compared in decode needs its operands earlier, so it is also held when a compared register is written by an ALU instruction directly ahead, or by a load that is currently in the memory stage; a load directly ahead therefore costs a branch two held cycles as that load moves from execute to memory. Finally, a taken branch squashes the instruction fetched behind it by raising a fetch flush, but only in a cycle where the branch is not being held.

All outputs are combinational functions of the current inputs; the clock and reset only qualify the embedded checks. The interfaces are plain control pins; there is no data stream and hence no valid/ready handshake.

Top module: `hzd_stall_unit`

## Requirements
- R1: When the execute-stage entry has memory-read set, a nonzero destination, and that destination equals either decode source, the unit holds (idex_bubble = 1), whether or not the decoding instruction is a branch.
- R2: idex_bubble is 1 exactly in the cycles in which any hold condition of R1, R4 or R5 is true, and 0 otherwise.
- R3: pc_we and ifid_we are both 0 while holding and both 1 when not holding.
- R4: When dec_is_branch is 1 and the execute-stage entry has register-write set, memory-read clear, and a nonzero destination equal to either decode source, the unit holds; the same entry does not hold a non-branch instruction.
- R5: When dec_is_branch is 1 and the memory-stage entry has memory-read set and a nonzero destination equal to either decode source, the unit holds; the same entry does not hold a non-branch instruction.
- R6: A branch that reads the register loaded by the instruction directly ahead of it is held for exactly two consecutive cycles (load in execute, then bubble in execute with the load in memory) and proceeds in the third.
- R7: if_flush is 1 exactly when dec_is_branch and br_taken are both 1 and the unit is not holding.
- R8: When a hold and a taken branch fall in the same cycle, the hold wins: idex_bubble = 1, if_flush = 0, and the flush appears only in the cycle the branch is released.
- R9: A destination register number of zero never causes a hold, in either stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used only by the embedded checks |
| rst_n | input | 1 | Active-low reset, disables the embedded checks |
| dec_src_a | input | REG_W | First source register number of the decoding instruction |
| dec_src_b | input | REG_W | Second source register number of the decoding instruction |
| dec_is_branch | input | 1 | Decoding instruction is a branch compared in decode |
| br_taken | input | 1 | Decode-stage comparator reports the branch taken |
| ex_mem_rd | input | 1 | Execute-stage entry reads data memory (is a load) |
| ex_reg_wr | input | 1 | Execute-stage entry writes a register |
| ex_dst | input | REG_W | Execute-stage entry destination register number |
| mem_mem_rd | input | 1 | Memory-stage entry reads data memory |
| mem_reg_wr | input | 1 | Memory-stage entry writes a register |
| mem_dst | input | REG_W | Memory-stage entry destination register number |
| pc_we | output | 1 | Fetch address may advance |
| ifid_we | output | 1 | Fetch/decode register may load |
| idex_bubble | output | 1 | Zero the control fields entering the execute stage |
| if_flush | output | 1 | Turn the fetched instruction in the fetch/decode register into a no-op |

## Verification
The hold and the fetch flush can fall in the same cycle: a taken branch whose compared register is still being produced by an execute-stage ALU instruction or by a load in either later stage. The sweep drives every combination of a narrow register width, so each such collision appears together with its clean counterparts, and judges that the flush stays low and the bubble high there. A separate short sequence walks a load ahead of a dependent taken branch through the stages and checks that the flush shows up only in the cycle after the second held cycle.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    HOLD_NONE   = 2'd0,
    HOLD_LDUSE  = 2'd1,
    HOLD_BR_ALU = 2'd2,
    HOLD_BR_LD  = 2'd3
  } hold_cause_e;

  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic bubble;
    logic flush;
  } hzd_ctl_t;

endpackage

// File: rtl/hzd_src_match.sv
// Compares one producer destination against every consumer source.
// Register zero is never a real producer.
module hzd_src_match #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [NSRC-1:0][REG_W-1:0] srcs,
  input  logic [REG_W-1:0]           dst,
  output logic                       hit
);
  logic [NSRC-1:0] eq_vec;
  logic            dst_live;

  assign dst_live = (dst != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_cmp
    assign eq_vec[g] = (srcs[g] == dst);
  end

  assign hit = dst_live && (|eq_vec);
endmodule

// File: rtl/hzd_load_use.sv
// One-cycle hold for a consumer of the load directly ahead.
module hzd_load_use #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [NSRC-1:0][REG_W-1:0] srcs,
  input  logic                       ex_mem_rd,
  input  logic [REG_W-1:0]           ex_dst,
  output logic                       hold
);
  logic hit;

  hzd_src_match #(.REG_W(REG_W), .NSRC(NSRC)) u_match (
    .srcs(srcs),
    .dst (ex_dst),
    .hit (hit)
  );

  assign hold = ex_mem_rd && hit;
endmodule

// File: rtl/hzd_branch_chk.sv
// Extra holds for a branch whose operands are compared in decode.
module hzd_branch_chk #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [NSRC-1:0][REG_W-1:0] srcs,
  input  logic                       is_branch,
  input  logic                       ex_mem_rd,
  input  logic                       ex_reg_wr,
  input  logic [REG_W-1:0]           ex_dst,
  input  logic                       mem_mem_rd,
  input  logic [REG_W-1:0]           mem_dst,
  output logic                       hold_alu,
  output logic                       hold_ld
);
  logic ex_hit;
  logic mem_hit;

  hzd_src_match #(.REG_W(REG_W), .NSRC(NSRC)) u_ex_match (
    .srcs(srcs),
    .dst (ex_dst),
    .hit (ex_hit)
  );

  hzd_src_match #(.REG_W(REG_W), .NSRC(NSRC)) u_mem_match (
    .srcs(srcs),
    .dst (mem_dst),
    .hit (mem_hit)
  );

  // ALU result directly ahead is not yet available at decode.
  assign hold_alu = is_branch && ex_reg_wr && !ex_mem_rd && ex_hit;
  // Load data is only returned at the end of the memory stage.
  assign hold_ld  = is_branch && mem_mem_rd && mem_hit;
endmodule

// File: rtl/hzd_stall_unit.sv
module hzd_stall_unit
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic             dec_is_branch,
  input  logic             br_taken,
  input  logic             ex_mem_rd,
  input  logic             ex_reg_wr,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             mem_mem_rd,
  input  logic             mem_reg_wr,
  input  logic [REG_W-1:0] mem_dst,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             idex_bubble,
  output logic             if_flush
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_W-1:0] srcs;
  logic        lu_hold;
  logic        br_alu_hold;
  logic        br_ld_hold;
  hold_cause_e cause;
  hzd_ctl_t    ctl;
  logic        mem_wr_unused;

  assign srcs[0] = dec_src_a;
  assign srcs[1] = dec_src_b;
  // A memory-stage register write is always forwardable to decode.
  assign mem_wr_unused = mem_reg_wr;

  hzd_load_use #(.REG_W(REG_W), .NSRC(NSRC)) u_load_use (
    .srcs     (srcs),
    .ex_mem_rd(ex_mem_rd),
    .ex_dst   (ex_dst),
    .hold     (lu_hold)
  );

  hzd_branch_chk #(.REG_W(REG_W), .NSRC(NSRC)) u_branch_chk (
    .srcs      (srcs),
    .is_branch (dec_is_branch),
    .ex_mem_rd (ex_mem_rd),
    .ex_reg_wr (ex_reg_wr),
    .ex_dst    (ex_dst),
    .mem_mem_rd(mem_mem_rd),
    .mem_dst   (mem_dst),
    .hold_alu  (br_alu_hold),
    .hold_ld   (br_ld_hold)
  );

  always_comb begin
    if (lu_hold)          cause = HOLD_LDUSE;
    else if (br_alu_hold) cause = HOLD_BR_ALU;
    else if (br_ld_hold)  cause = HOLD_BR_LD;
    else                  cause = HOLD_NONE;
  end

  always_comb begin
    ctl = '{pc_we: 1'b1, ifid_we: 1'b1, bubble: 1'b0, flush: 1'b0};
    if (cause != HOLD_NONE) begin
      ctl.pc_we   = 1'b0;
      ctl.ifid_we = 1'b0;
      ctl.bubble  = 1'b1;
    end else begin
      // Flush only once the branch is released.
      ctl.flush = dec_is_branch && br_taken;
    end
  end

  assign pc_we       = ctl.pc_we;
  assign ifid_we     = ctl.ifid_we;
  assign idex_bubble = ctl.bubble;
  assign if_flush    = ctl.flush;

  // R1
  ld_use_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_mem_rd && ex_dst != '0 && (ex_dst == dec_src_a || ex_dst == dec_src_b))
      |-> idex_bubble);
  // R3
  freeze_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> (!pc_we && !ifid_we));
  // R3
  advance_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idex_bubble |-> (pc_we && ifid_we));
  // R7
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_flush |-> (dec_is_branch && br_taken));
  // R8
  hold_beats_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(if_flush && idex_bubble));
  // R9
  zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == '0 && mem_dst == '0) |-> !idex_bubble);
  // R4
  nonbranch_alu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_is_branch && !ex_mem_rd) |-> !idex_bubble);
endmodule

// File: tb/hzd_stall_unit_bench.sv
module hzd_stall_unit_bench;
  localparam int RW = 2;
  localparam int NVEC = 1 << (4*RW + 6);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [RW-1:0] src_a = '0, src_b = '0, ex_dst = '0, mem_dst = '0;
  logic          is_br = 1'b0, tk = 1'b0;
  logic          ex_mr = 1'b0, ex_rw = 1'b0, mem_mr = 1'b0, mem_rw = 1'b0;
  logic          pc_we, ifid_we, bub, flush;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hzd_stall_unit #(.REG_W(RW)) u_hzd_stall_unit (
    .clk(clk), .rst_n(rst_n),
    .dec_src_a(src_a), .dec_src_b(src_b),
    .dec_is_branch(is_br), .br_taken(tk),
    .ex_mem_rd(ex_mr), .ex_reg_wr(ex_rw), .ex_dst(ex_dst),
    .mem_mem_rd(mem_mr), .mem_reg_wr(mem_rw), .mem_dst(mem_dst),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(bub), .if_flush(flush)
  );

  task automatic chk(input string req, input string what,
                     input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    logic ex_hit, mem_hit, lu, bra, brl, hold, fl;
    string req;
    ex_hit  = (ex_dst != '0) && (ex_dst == src_a || ex_dst == src_b);
    mem_hit = (mem_dst != '0) && (mem_dst == src_a || mem_dst == src_b);
    lu   = ex_mr && ex_hit;
    bra  = is_br && ex_rw && !ex_mr && ex_hit;
    brl  = is_br && mem_mr && mem_hit;
    hold = lu | bra | brl;
    fl   = is_br && tk && !hold;
    if (lu)       req = "R1";
    else if (bra) req = "R4";
    else if (brl) req = "R5";
    else if (ex_dst == '0 && mem_dst == '0) req = "R9";
    else          req = "R2";
    chk(req, "idex_bubble", bub, hold);
    chk("R3", "pc_we", pc_we, !hold);
    chk("R3", "ifid_we", ifid_we, !hold);
    chk((hold && is_br && tk) ? "R8" : "R7", "if_flush", flush, fl);
  endtask

  task automatic drive(input logic [RW-1:0] a, input logic [RW-1:0] b,
                       input logic br, input logic t,
                       input logic emr, input logic erw, input logic [RW-1:0] ed,
                       input logic mmr, input logic mrw, input logic [RW-1:0] md);
    @(posedge clk);
    #1;
    src_a = a; src_b = b; is_br = br; tk = t;
    ex_mr = emr; ex_rw = erw; ex_dst = ed;
    mem_mr = mmr; mem_rw = mrw; mem_dst = md;
    @(negedge clk);
  endtask

  initial begin
    int holds;
    // reset state with idle pipeline
    @(negedge clk);
    chk("R3", "reset pc_we", pc_we, 1'b1);
    chk("R2", "reset idex_bubble", bub, 1'b0);
    chk("R7", "reset if_flush", flush, 1'b0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;

    // exhaustive sweep over the narrow configuration
    for (int v = 0; v < NVEC; v++) begin
      logic [4*RW+5:0] w;
      w = v[4*RW+5:0];
      drive(w[RW-1:0], w[2*RW-1:RW], w[2*RW], w[2*RW+1],
            w[2*RW+2], w[2*RW+3], w[3*RW+3:2*RW+4],
            w[3*RW+4], w[3*RW+5], w[4*RW+5:3*RW+6]);
      check_all();
    end

    // R6: load directly ahead of a taken branch reading r1
    holds = 0;
    drive(2'd1, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 2'd0);
    check_all(); if (bub) holds++;
    drive(2'd1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd1);
    check_all(); if (bub) holds++;
    drive(2'd1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0);
    check_all();
    chk("R6", "two held cycles", (holds == 2), 1'b1);
    chk("R8", "flush on release", flush, 1'b1);

    // R4: ALU directly ahead costs a branch one cycle
    holds = 0;
    drive(2'd3, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 2'd0);
    check_all(); if (bub) holds++;
    drive(2'd3, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd2);
    check_all(); if (bub) holds++;
    chk("R4", "one held cycle", (holds == 1), 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      miscompares++;
      $display("FAIL R2 watchdog: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule